// File: doc/BRIEF.md
# Selector-Based Small-Coefficient Multiply-Accumulate Cell

This cell is one lane of a linear-time polynomial multiplier. Each cycle a large coefficient `b_i`, held as a balanced residue modulo `Q`, is broadcast to every lane. Each lane also holds a small signed coefficient `a_i` whose magnitude is at most `(P-1)/2`. The lane adds the product `a_i * b_i` to its own accumulator. The cell has no hardware multiplier. It builds the positive multiples `b, 2b, ... , K*b` with a short chain of adders, where `K = (P-1)/2`. It then picks the right multiple, or its negation, from the value of `a_i`.

The reduction policy is fixed by a parameter. In the folded policy the accumulator stays a balanced residue modulo `Q` in `ceil(log2 Q)` bits. The raw sum is corrected by adding or subtracting several multiples of `Q` in parallel, and the one candidate that falls in range is kept. In the deferred policy the accumulator is widened to `ceil(log2(2*N*P*Q))+1` bits and holds the exact integer sum, so that one reducer at readout can do the work. When `Q` is a power of two, the folded policy becomes a plain wrap to `log2 Q` bits. The deferred policy is then refused at elaboration.

Top module: `mac_cell`

## Requirements
- R1: While `rst_n` is low, the accumulator output `acc_o` is zero.
- R2: A cycle with `clr_i` high leaves `acc_o` at zero after the next rising clock edge, whatever `en_i`, `a_i` and `b_i` are. Clear has priority over enable.
- R3: A cycle with `en_i` low and `clr_i` low leaves `acc_o` unchanged.
- R4: In the folded policy with odd `Q`, an enabled cycle makes `acc_o` (two's complement) the residue of `acc_o + a_i*b_i` modulo `Q` that lies in `[-(Q-1)/2, (Q-1)/2]`.
- R5: Every small value `a_i` in `[-(P-1)/2, (P-1)/2]` (two's complement on `a_i`) adds exactly `a_i*b_i`, for any `b_i` in `[-(Q-1)/2, (Q-1)/2]`. A zero `a_i` adds nothing.
- R6: A folded sum of exactly `+(Q-1)/2` or `-(Q-1)/2` is kept as it is. A sum one step past either end wraps to the opposite end.
- R7: In the deferred policy, an enabled cycle makes `acc_o` the exact signed integer `acc_o + a_i*b_i`, with no modular correction.
- R8: When `Q` is a power of two, an enabled cycle makes `acc_o` the sum `acc_o + a_i*b_i` wrapped to `log2 Q` bits in two's complement, in the range `[-Q/2, Q/2-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the accumulator |
| en_i | input | 1 | Accumulate enable |
| b_i | input | QW = ceil(log2 Q) | Broadcast large coefficient, balanced signed residue |
| a_i | input | AW = ceil(log2(K+1))+1 | Local small signed coefficient, K = (P-1)/2 |
| acc_o | output | ACC_W | Accumulator: QW bits when folded, ceil(log2(2NPQ))+1 bits when deferred |

## Verification
The bench drives extreme multiples such as `+-2*1664` against accumulators near the edge of the balanced range. A fold stage that lacks one of its correction multiples, or that uses a wrong limit, would leave a value outside `+-1664` or one `Q` away from the expected value. Sums that land exactly on `+-(Q-1)/2` and one step beyond catch off-by-one range comparisons. A sweep of every small coefficient against random large ones exposes a selector that swaps a multiple or drops the sign. Clear-with-enable and enable-low cycles show whether clear really has priority and whether the hold path leaks. The power-of-two instance shows whether the wrap keeps the low bits rather than saturating.

// File: rtl/mac_cell_pkg.sv
package mac_cell_pkg;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int small_mag(input int p);
      return (p - 1) / 2;
   endfunction

   function automatic int coef_width(input int q);
      return $clog2(q);
   endfunction

   function automatic int small_width(input int p);
      return $clog2(small_mag(p) + 1) + 1;
   endfunction

   function automatic int wide_width(input int n, input int p, input int q);
      longint span;
      span = 64'd2 * longint'(n) * longint'(p) * longint'(q);
      return $clog2(span) + 1;
   endfunction

   function automatic int acc_width(input int n, input int p, input int q, input bit defer);
      return defer ? wide_width(n, p, q) : coef_width(q);
   endfunction

   function automatic int prod_width(input int q, input int p);
      return coef_width(q) + $clog2(small_mag(p) + 1) + 1;
   endfunction

   function automatic int fold_width(input int q, input int p);
      return coef_width(q) + $clog2(2 * small_mag(p) + 2) + 2;
   endfunction

endpackage

// File: rtl/mac_multiple_sel.sv
module mac_multiple_sel #(
   parameter int BW   = 12,
   parameter int AWID = 3,
   parameter int KMAX = 2,
   parameter int PW   = 16
) (
   input  logic signed [BW-1:0]   b_i,
   input  logic signed [AWID-1:0] a_i,
   output logic signed [PW-1:0]   prod_o
);
   localparam int NCAND = KMAX + 1;

   logic signed [PW-1:0] pos [NCAND];
   logic signed [PW-1:0] neg [NCAND];
   logic signed [PW-1:0] bx;

   assign bx = PW'(b_i);

   // Positive multiples by repeated addition; negatives by one subtraction each
   always_comb begin
      pos[0] = '0;
      for (int k = 1; k < NCAND; k++) begin
         pos[k] = pos[k-1] + bx;
      end
   end

   generate
      for (genvar k = 0; k < NCAND; k++) begin : g_neg
         assign neg[k] = -pos[k];
      end
   endgenerate

   // Selector keyed by the small coefficient
   always_comb begin
      prod_o = '0;
      for (int k = 1; k < NCAND; k++) begin
         if (a_i == AWID'(k)) begin
            prod_o = pos[k];
         end else if (a_i == -AWID'(k)) begin
            prod_o = neg[k];
         end
      end
   end

endmodule

// File: rtl/mac_modq_fold.sv
module mac_modq_fold #(
   parameter int Q  = 3329,
   parameter int M  = 2,
   parameter int SW = 17,
   parameter int RW = 12
) (
   input  logic signed [SW-1:0] sum_i,
   output logic signed [RW-1:0] res_o
);
   localparam int NCAND = 2 * M + 1;
   localparam int HALF  = (Q - 1) / 2;
   localparam logic signed [SW-1:0] HI = SW'(HALF);
   localparam logic signed [SW-1:0] LO = -SW'(HALF);

   logic signed [SW-1:0] cand [NCAND];
   logic [NCAND-1:0]     hit;

   // Parallel candidates: sum minus j*Q for j in [-M, M]
   generate
      for (genvar j = 0; j < NCAND; j++) begin : g_cand
         localparam int OFS = (j - M) * Q;
         assign cand[j] = sum_i - SW'(OFS);
         assign hit[j]  = (cand[j] >= LO) && (cand[j] <= HI);
      end
   endgenerate

   // At most one candidate lies in a window narrower than Q
   always_comb begin
      res_o = '0;
      for (int j = 0; j < NCAND; j++) begin
         if (hit[j]) begin
            res_o = RW'(cand[j]);
         end
      end
   end

endmodule

// File: rtl/mac_cell.sv
module mac_cell
   import mac_cell_pkg::*;
#(
   parameter int  Q     = 3329,
   parameter int  P     = 5,
   parameter int  N     = 256,
   parameter bit  DEFER = 1'b0,
   localparam int QW    = coef_width(Q),
   localparam int AW    = small_width(P),
   localparam int ACC_W = acc_width(N, P, Q, DEFER)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic                    en_i,
   input  logic signed [QW-1:0]    b_i,
   input  logic signed [AW-1:0]    a_i,
   output logic signed [ACC_W-1:0] acc_o
);
   localparam int  KMAX = small_mag(P);
   localparam int  PW   = prod_width(Q, P);
   localparam int  SW   = fold_width(Q, P);
   localparam bit  POW2 = is_pow2(Q);

   // Elaboration-time parameter checks
   generate
      if ((P < 3) || (P > 11) || ((P % 2) == 0)) begin : g_bad_p
         $error("mac_cell: P must be odd and within 3..11");
      end
      if (Q < 3) begin : g_bad_q
         $error("mac_cell: Q must be at least 3");
      end
      if (!POW2 && ((Q % 2) == 0)) begin : g_bad_q_even
         $error("mac_cell: Q must be odd or a power of two");
      end
      if (POW2 && DEFER) begin : g_bad_defer
         $error("mac_cell: deferred policy is pointless for power-of-two Q");
      end
      if (N < 1) begin : g_bad_n
         $error("mac_cell: N must be positive");
      end
   endgenerate

   logic signed [PW-1:0]    prod;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] acc_nxt;

   mac_multiple_sel #(
      .BW   (QW),
      .AWID (AW),
      .KMAX (KMAX),
      .PW   (PW)
   ) u_sel (
      .b_i    (b_i),
      .a_i    (a_i),
      .prod_o (prod)
   );

   // Reduction policy variants
   generate
      if (DEFER) begin : g_defer
         assign acc_nxt = acc_q + ACC_W'(prod);
      end else if (POW2) begin : g_wrap
         assign acc_nxt = acc_q + ACC_W'(prod);
      end else begin : g_fold
         logic signed [SW-1:0] raw;
         assign raw = SW'(acc_q) + SW'(prod);
         mac_modq_fold #(
            .Q  (Q),
            .M  (KMAX),
            .SW (SW),
            .RW (ACC_W)
         ) u_fold (
            .sum_i (raw),
            .res_o (acc_nxt)
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr_i) begin
         acc_q <= '0;
      end else if (en_i) begin
         acc_q <= acc_nxt;
      end
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/mac_cell_chk.sv
module mac_cell_chk
   import mac_cell_pkg::*;
#(
   parameter int  Q     = 3329,
   parameter int  P     = 5,
   parameter int  N     = 256,
   parameter bit  DEFER = 1'b0,
   localparam int QW    = coef_width(Q),
   localparam int AW    = small_width(P),
   localparam int ACC_W = acc_width(N, P, Q, DEFER)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    clr_i,
   input logic                    en_i,
   input logic signed [QW-1:0]    b_i,
   input logic signed [AW-1:0]    a_i,
   input logic signed [ACC_W-1:0] acc_o
);
   localparam longint HALF = longint'((Q - 1) / 2);
   localparam longint STEP = longint'(small_mag(P)) * HALF;

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (acc_o == '0));  // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !en_i) |=> $stable(acc_o));  // R3

   AST_ZERO_COEF: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && en_i && (a_i == '0)) |=> $stable(acc_o));  // R5

   generate
      if (!DEFER && !is_pow2(Q)) begin : g_fold_chk
         AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (longint'(acc_o) <= HALF) && (longint'(acc_o) >= -HALF));  // R4
      end
      if (DEFER) begin : g_defer_chk
         AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i && en_i) |=>
               ((longint'(acc_o) - longint'($past(acc_o))) <= STEP) &&
               ((longint'(acc_o) - longint'($past(acc_o))) >= -STEP));  // R7
      end
   endgenerate

endmodule

bind mac_cell mac_cell_chk #(
   .Q     (Q),
   .P     (P),
   .N     (N),
   .DEFER (DEFER)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .clr_i (clr_i),
   .en_i  (en_i),
   .b_i   (b_i),
   .a_i   (a_i),
   .acc_o (acc_o)
);

// File: tb/sim_mac_cell.sv
module sim_mac_cell;
   localparam int QP = 3329;
   localparam int Q2 = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic en = 1'b0;
   logic signed [11:0] b = '0;
   logic signed [2:0]  a = '0;
   logic signed [1:0]  a2 = '0;
   logic signed [11:0] acc0;
   logic signed [24:0] acc1;
   logic signed [11:0] acc2;

   int errors = 0;
   int checks = 0;
   longint m0 = 0, m1 = 0, m2 = 0;

   always #4 clk = ~clk;

   mac_cell #(.Q(QP), .P(5), .N(256), .DEFER(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(en), .b_i(b), .a_i(a), .acc_o(acc0));
   mac_cell #(.Q(QP), .P(5), .N(256), .DEFER(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(en), .b_i(b), .a_i(a), .acc_o(acc1));
   mac_cell #(.Q(Q2), .P(3), .N(256), .DEFER(1'b0)) u2 (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(en), .b_i(b), .a_i(a2), .acc_o(acc2));

   // Columns: clr, en, a, b, folded expectation, deferred expectation
   localparam int NV = 16;
   localparam int TAB [NV][6] = '{
      '{1, 0,  0,     0,     0,     0},
      '{0, 1,  2,  1000, -1329,  2000},
      '{0, 1,  2,  1000,   671,  4000},
      '{0, 1, -2,  1664,   672,   672},
      '{0, 0,  2,   500,   672,   672},
      '{0, 1, -1, -1664,  -993,  2336},
      '{0, 1,  0,  1234,  -993,  2336},
      '{0, 1,  1,    -1,  -994,  2335},
      '{0, 1, -2, -1664,  -995,  5663},
      '{1, 1,  2,     5,     0,     0},
      '{0, 1,  2, -1664,     1, -3328},
      '{0, 1, -2,  1664,     2, -6656},
      '{0, 1,  1,  1664, -1663, -4992},
      '{0, 1, -1,  1664,     2, -6656},
      '{0, 1,  1,  1662,  1664, -4994},
      '{0, 1,  1,     1, -1664, -4993}
   };

   function automatic longint bal_q(input longint v);
      longint r;
      r = v % QP;
      if (r < 0) r += QP;
      if (r > (QP - 1) / 2) r -= QP;
      return r;
   endfunction

   function automatic longint wrap_q2(input longint v);
      longint r;
      r = v % Q2;
      if (r < 0) r += Q2;
      if (r >= Q2 / 2) r -= Q2;
      return r;
   endfunction

   function automatic int clamp1(input int v);
      return (v > 1) ? 1 : ((v < -1) ? -1 : v);
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Apply one cycle of stimulus and update the bench models
   task automatic step(input int c, input int e, input int av, input int bv);
      @(negedge clk);
      clr = c[0];
      en  = e[0];
      a   = 3'(av);
      a2  = 2'(clamp1(av));
      b   = 12'(bv);
      @(posedge clk);
      #2;
      if (c != 0) begin
         m0 = 0; m1 = 0; m2 = 0;
      end else if (e != 0) begin
         m0 = bal_q(m0 + longint'(av) * bv);
         m1 = m1 + longint'(av) * bv;
         m2 = wrap_q2(m2 + longint'(clamp1(av)) * bv);
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #2;
      check("R1 folded", acc0, 0);
      check("R1 deferred", acc1, 0);
      check("R1 wrap", acc2, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk: R2 clear, R3 hold, R4 fold, R5 selection, R6 edges, R7 deferred, R8 wrap
      for (int i = 0; i < NV; i++) begin
         step(TAB[i][0], TAB[i][1], TAB[i][2], TAB[i][3]);
         check("R4/R6 folded table", acc0, TAB[i][4]);
         check("R7 deferred table", acc1, TAB[i][5]);
         check("R8 wrap table", acc2, m2);
      end

      // R5: sweep every small coefficient against random large ones
      step(1, 0, 0, 0);
      for (int av = -2; av <= 2; av++) begin
         for (int n = 0; n < 40; n++) begin
            int bv;
            bv = int'($urandom_range(3328, 0)) - 1664;
            step(0, 1, av, bv);
            check("R5 folded sweep", acc0, m0);
            check("R5 deferred sweep", acc1, m1);
            check("R8 wrap sweep", acc2, m2);
         end
      end
      check("R7 deferred agrees with fold", bal_q(longint'(acc1)), longint'(acc0));

      // R3: hold with enable low and busy inputs
      step(0, 0, -2, -1500);
      check("R3 folded hold", acc0, m0);
      check("R3 deferred hold", acc1, m1);

      // R2: clear with enable high
      step(1, 1, 2, 1664);
      check("R2 folded clear", acc0, 0);
      check("R2 deferred clear", acc1, 0);
      check("R2 wrap clear", acc2, 0);

      // R8: drive the power-of-two lane across its top edge
      step(0, 1, 1, 1664);
      step(0, 1, 1, 383);
      check("R8 wrap top edge", acc2, 2047);
      step(0, 1, 1, 1);
      check("R8 wrap past edge", acc2, -2048);

      // R6: lower edge of the folded range
      step(1, 0, 0, 0);
      step(0, 1, -1, 1664);
      check("R6 lower edge kept", acc0, -1664);
      step(0, 1, -1, 1);
      check("R6 lower edge wraps", acc0, 1664);

      // R1: reset in mid-run
      step(0, 1, 2, 1000);
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R1 async reset folded", acc0, 0);
      check("R1 async reset deferred", acc1, 0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule